// File: doc/BRIEF.md
# Converter Serial Read-Out Port Controller

This block is the digital side of a three-wire read-out port for a converter that sleeps between conversions. It runs a behavioural conversion engine, a counter of fixed length that yields a result word, and moves through three phases: conversion, sleep and data output. An active-low chip select wakes the block and enables the data pin. Outside the data output phase the data pin shows whether a conversion is still running. During data output it shifts out a 24-bit result frame.

The serial clock pin works in one of two directions. If the pin is high at reset, or at the latest falling edge of chip select, the block uses internal clocking: it drives the clock itself, turns on a weak pull-up, and starts the transfer as soon as a result is ready. If the pin is low at that moment, the host supplies the clock. Raising chip select during a transfer abandons the transfer and starts a fresh conversion. Input values beyond half of full scale produce their own out-of-range codes rather than clipped data.

Top module: `adcp_port`

## Requirements
- R1: During reset and on the cycle it is released, the block is in the conversion phase. The clock mode is taken from `sck_in` while reset is held.
- R2: `sdo_oe` is high exactly while `cs_n` is low. The data pin is released (high impedance) whenever chip select is high.
- R3: While chip select is low, `sdo` reads 1 during conversion (busy) and 0 once the result is ready (end of conversion).
- R4: A conversion lasts `CONV_CYC` clock cycles. It ends on the `CONV_CYC`-th rising edge after the block enters the conversion phase.
- R5: After a conversion the block sleeps for as long as `cs_n` stays high. The result is kept, and a later falling edge of chip select wakes the block straight into data output.
- R6: The frame is 24 bits and goes out most significant bit first. Bit 23 is the status bit (0). Bit 22 is the sign (1 when `vin` is zero or above). Bit 21 is the out-of-range flag (0 when in range). Bits 20..0 are the low 21 bits of `vin` in two's complement. The in-range span is -2^20 to 2^20-1.
- R7: When `vin` is 2^20 or more, the frame is sign 1, flag 1, data 0 (0x600000). When `vin` is below -2^20, the frame is sign 0, flag 1, data 0 (0x200000).
- R8: In internal mode `sck_out` has a period of `DIV` cycles. It starts low, is high for the second half of each period, and `sdo` moves to the next bit only after a falling edge. The transfer starts by itself when the result is ready and chip select is low.
- R9: In external mode the frame advances one bit on each falling edge of `sck_in`. No bit moves without a host clock edge.
- R10: The clock mode changes only at a falling edge of `cs_n` (internal if `sck_in` is 1, external if 0). `sck_pullup` shows internal mode. `sck_oe` is high only in internal mode during data output.
- R11: A rising edge of `cs_n` during data output cancels the transfer and starts a new conversion of full length.
- R12: Once the last bit has been shifted out, a new conversion starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sck_in | input | 1 | Level seen on the serial clock pin |
| vin | input | IN_W | Signed sample the conversion engine digitises |
| sck_out | output | 1 | Clock level driven in internal mode |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sck_pullup | output | 1 | Weak pull-up enable on the clock pin |
| sdo | output | 1 | Serial data / conversion status value |
| sdo_oe | output | 1 | Drive enable for the data pin |

## Verification
The hardest states to reach from the ports are the cancelled transfer and a transfer in external mode that has reached end of conversion but has had no host clock. In both, the data pin looks the same as in a quiet sleep. The bench waits for the first internal clock rise, then raises chip select, and counts the busy cycles that follow to check that a full new conversion was started. It then switches mode at a chip-select fall with the clock pin low. It picks a positive sample so that a stray bit advance would put a 1 on the data pin, waits several divider periods, and only then clocks the frame out by hand.

// File: rtl/adcp_pkg.sv
// Shared types for the converter read-out port.
// Assumes: nothing beyond the project's own modules use these names.
package adcp_pkg;

    // Phase of the port sequencer
    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_SEND  = 2'd2
    } phase_t;

endpackage

// File: rtl/adcp_conv.sv
// Behavioural conversion engine: counts CONV_CYC cycles while run is high,
// then captures vin into a formatted result word (status, sign, range flag, data).
// Assumes: IN_W > DATA_W, and vin is stable around the last conversion cycle.
module adcp_conv #(
    parameter int CONV_CYC = 40,
    parameter int IN_W     = 24,
    parameter int DATA_W   = 21,
    localparam int FRAME_W = DATA_W + 3,
    localparam int CNT_W   = $clog2(CONV_CYC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic signed [IN_W-1:0]    vin,
    output logic                      done,
    output logic [FRAME_W-1:0]        word
);

    localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(1) << (DATA_W - 1);
    localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM;

    logic [CNT_W-1:0]   cnt;
    logic               over;
    logic               under;
    logic [FRAME_W-1:0] next_word;

    assign done = run && (cnt == CNT_W'(CONV_CYC - 1));

    // Conversion timer: counts only while converting, clears at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Range decision and frame formatting of the sample
    always_comb begin
        over  = (vin >= POS_LIM);
        under = (vin < NEG_LIM);
        if (over) begin
            next_word = {1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};
        end else if (under) begin
            next_word = {1'b0, 1'b0, 1'b1, {DATA_W{1'b0}}};
        end else begin
            next_word = {1'b0, ~vin[IN_W-1], 1'b0, vin[DATA_W-1:0]};
        end
    end

    // Result register, loaded on the last conversion cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (done) begin
            word <= next_word;
        end
    end

endmodule

// File: rtl/adcp_sck.sv
// Serial clock unit: divides clk by DIV for internal mode and detects the
// falling edges of the host clock in external mode; fall pulses advance the frame.
// Assumes: DIV >= 2, sck_in already synchronous to clk.
module adcp_sck #(
    parameter int DIV = 4,
    localparam int DCNT_W   = (DIV > 2) ? $clog2(DIV) : 1,
    localparam int HALF_DIV = DIV / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic int_mode,
    input  logic sck_in,
    output logic sck_int,
    output logic fall
);

    logic [DCNT_W-1:0] dcnt;
    logic              sck_q;
    logic              wrap;

    assign wrap = (dcnt == DCNT_W'(DIV - 1));

    // Divider counter, held at zero outside data output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (!active || wrap) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // Previous host clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_in;
        end
    end

    assign sck_int = active && (dcnt >= DCNT_W'(HALF_DIV));
    assign fall    = active && (int_mode ? wrap : (sck_q && !sck_in));

endmodule

// File: rtl/adcp_shift.sv
// Frame serializer: presents one bit of the result word, MSB first, and steps
// to the next bit on each step pulse; flags the step that ends the frame.
// Assumes: word is stable while active.
module adcp_shift #(
    parameter int FRAME_W = 24,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               step,
    input  logic [FRAME_W-1:0] word,
    output logic               bit_out,
    output logic               last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pos;

    // Bit index, cleared whenever no transfer is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!active) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    assign pos     = LAST_IDX - idx;
    assign bit_out = word[pos];
    assign last    = active && step && (idx == LAST_IDX);

endmodule

// File: rtl/adcp_port.sv
// Converter read-out port top: sequences conversion, sleep and data output,
// shows conversion status on the data pin, picks the clock direction from the
// clock pin at reset or at a chip-select fall, and aborts on chip-select rise.
// Assumes: cs_n and sck_in are synchronous to clk; pads apply the enables.
module adcp_port
    import adcp_pkg::*;
#(
    parameter int CONV_CYC = 40,
    parameter int DIV      = 4,
    parameter int IN_W     = 24,
    parameter int DATA_W   = 21,
    localparam int FRAME_W = DATA_W + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sck_in,
    input  logic signed [IN_W-1:0] vin,
    output logic                   sck_out,
    output logic                   sck_oe,
    output logic                   sck_pullup,
    output logic                   sdo,
    output logic                   sdo_oe
);

    phase_t             phase;
    logic               cs_q;
    logic               int_mode;
    logic               conv_done;
    logic [FRAME_W-1:0] frame_word;
    logic               sck_int;
    logic               shift_step;
    logic               data_bit;
    logic               frame_last;
    logic               sending;

    assign sending = (phase == PH_SEND);

    adcp_conv #(
        .CONV_CYC (CONV_CYC),
        .IN_W     (IN_W),
        .DATA_W   (DATA_W)
    ) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_CONV),
        .vin   (vin),
        .done  (conv_done),
        .word  (frame_word)
    );

    adcp_sck #(
        .DIV (DIV)
    ) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (sending),
        .int_mode (int_mode),
        .sck_in   (sck_in),
        .sck_int  (sck_int),
        .fall     (shift_step)
    );

    adcp_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (sending),
        .step    (shift_step),
        .word    (frame_word),
        .bit_out (data_bit),
        .last    (frame_last)
    );

    // Phase sequencer: convert, sleep until selected, send until done or aborted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CONV;
        end else begin
            unique case (phase)
                PH_CONV:  if (conv_done) phase <= PH_SLEEP;
                PH_SLEEP: if (!cs_n) phase <= PH_SEND;
                PH_SEND:  if (cs_n || frame_last) phase <= PH_CONV;
                default:  phase <= PH_CONV;
            endcase
        end
    end

    // Clock mode latch: sample the clock pin in reset and at chip-select fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= cs_n;
            int_mode <= sck_in;
        end else begin
            cs_q <= cs_n;
            if (cs_q && !cs_n) begin
                int_mode <= sck_in;
            end
        end
    end

    // Data pin: busy status, ready status or frame bit
    always_comb begin
        unique case (phase)
            PH_CONV:  sdo = 1'b1;
            PH_SLEEP: sdo = 1'b0;
            default:  sdo = data_bit;
        endcase
    end

    assign sdo_oe     = !cs_n;
    assign sck_out    = int_mode && sck_int;
    assign sck_oe     = int_mode && sending;
    assign sck_pullup = int_mode;

endmodule

// File: rtl/adcp_port_chk.sv
// Property checker for the read-out port, bound into every adcp_port instance.
// Assumes: it observes the top's own phase, mode and sequencing signals.
module adcp_port_chk
    import adcp_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_n,
    input logic   sck_out,
    input logic   sck_oe,
    input phase_t phase,
    input logic   conv_done,
    input logic   cs_q,
    input logic   int_mode,
    input logic   frame_last
);

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && cs_n) |=> (phase == PH_CONV));                 // R11

    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && !conv_done) |=> (phase == PH_CONV));           // R4

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP && cs_n) |=> (phase == PH_SLEEP));               // R5

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_q && !cs_n) |=> $stable(int_mode));                            // R10

    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && !cs_n && frame_last) |=> (phase == PH_CONV));  // R12

    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_SEND) |-> (!sck_oe && !sck_out));                      // R8

endmodule

bind adcp_port adcp_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck_out    (sck_out),
    .sck_oe     (sck_oe),
    .phase      (phase),
    .conv_done  (conv_done),
    .cs_q       (cs_q),
    .int_mode   (int_mode),
    .frame_last (frame_last)
);

// File: tb/adcp_port_test.sv
// Self-checking bench for adcp_port: a vector table of samples and frames,
// then directed tests for sleep, abort, latency and external clocking.
module adcp_port_test;

    localparam int CLK_PER  = 10;
    localparam int CONV_CYC = 40;
    localparam int DIV      = 4;
    localparam int IN_W     = 24;
    localparam int DATA_W   = 21;
    localparam int NVEC     = 9;
    localparam int WD_CYC   = 20000;

    localparam logic [IN_W-1:0] VIN_TAB [NVEC] = '{
        24'h000000, 24'h000005, 24'hFFFFFF, 24'h0FFFFF, 24'hF00000,
        24'h100000, 24'hEFFFFF, 24'h7FFFFF, 24'h800000
    };
    localparam logic [23:0] EXP_TAB [NVEC] = '{
        24'h400000, 24'h400005, 24'h1FFFFF, 24'h4FFFFF, 24'h100000,
        24'h600000, 24'h200000, 24'h600000, 24'h200000
    };

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   cs_n;
    logic                   sck_in;
    logic signed [IN_W-1:0] vin;
    logic                   sck_out;
    logic                   sck_oe;
    logic                   sck_pullup;
    logic                   sdo;
    logic                   sdo_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    adcp_port #(
        .CONV_CYC (CONV_CYC),
        .DIV      (DIV),
        .IN_W     (IN_W),
        .DATA_W   (DATA_W)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck_in     (sck_in),
        .vin        (vin),
        .sck_out    (sck_out),
        .sck_oe     (sck_oe),
        .sck_pullup (sck_pullup),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Collect 24 bits at internal clock rises; report spacing of first two rises
    task automatic read_int(output logic [23:0] fr, output int period);
        logic prev;
        int rises;
        int t;
        int t1;
        int t2;
        fr = '0; rises = 0; t = 0; t1 = 0; t2 = 0;
        prev = sck_out;
        while (rises < 24 && t < 2000) begin
            @(negedge clk);
            t++;
            if (sck_out && !prev) begin
                fr = {fr[22:0], sdo};
                rises++;
                if (rises == 1) t1 = t;
                if (rises == 2) t2 = t;
            end
            prev = sck_out;
        end
        period = t2 - t1;
    endtask

    // Clock 24 bits out as host: sample, raise, wait, lower, wait
    task automatic read_ext(output logic [23:0] fr);
        fr = '0;
        for (int i = 0; i < 24; i++) begin
            fr = {fr[22:0], sdo};
            sck_in = 1'b1;
            repeat (2) @(negedge clk);
            sck_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // Wait for end-of-conversion status, counting cycles
    task automatic wait_eoc(output int cyc);
        cyc = 0;
        while (sdo !== 1'b0 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] fr;
        int period;
        int cyc;

        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sck_in = 1'b1;
        vin    = VIN_TAB[0];
        repeat (5) @(negedge clk);

        // R1 R2 R10: reset state, internal mode taken from high clock pin
        check("R2 reset oe", {31'd0, sdo_oe}, 32'd0);
        check("R10 reset pullup", {31'd0, sck_pullup}, 32'd1);
        check("R10 reset sck_oe", {31'd0, sck_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        #1;
        check("R1 busy after reset", {31'd0, sdo}, 32'd1);
        cs_n = 1'b1;

        // R5: sleep holds while deselected; selection wakes with status ready
        repeat (CONV_CYC + 30) @(negedge clk);
        check("R5 idle oe", {31'd0, sdo_oe}, 32'd0);
        check("R5 idle sck_oe", {31'd0, sck_oe}, 32'd0);
        cs_n = 1'b0;
        #1;
        check("R2 oe on select", {31'd0, sdo_oe}, 32'd1);
        check("R3 ready status", {31'd0, sdo}, 32'd0);

        // R6 R7 R8 R12: vector table walked with automatic internal transfers
        for (int i = 0; i < NVEC; i++) begin
            if (i > 0) vin = VIN_TAB[i];
            read_int(fr, period);
            check($sformatf("R6 R7 frame vec%0d", i), {8'd0, fr}, {8'd0, EXP_TAB[i]});
            check("R8 sck period", period, DIV);
            repeat (DIV) @(negedge clk);
            check("R12 new conversion busy", {31'd0, sdo}, 32'd1);
        end

        // R11 R4: abort after first clock rise, then time the new conversion
        vin = 24'h000123;
        wait_eoc(cyc);
        begin
            logic prev;
            prev = sck_out;
            cyc = 0;
            while (!(sck_out && !prev) && cyc < 100) begin
                prev = sck_out;
                @(negedge clk);
                cyc++;
            end
        end
        cs_n = 1'b1;
        #1;
        check("R2 oe released on abort", {31'd0, sdo_oe}, 32'd0);
        @(negedge clk);
        cs_n = 1'b0;
        #1;
        check("R11 busy after abort", {31'd0, sdo}, 32'd1);
        cyc = 1;
        while (sdo !== 1'b0 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check("R4 conversion length", cyc, CONV_CYC + 1);
        read_int(fr, period);
        check("R11 frame after abort", {8'd0, fr}, 32'h00400123);

        // R9 R10: external clocking chosen at chip-select fall with pin low
        repeat (DIV) @(negedge clk);
        vin = 24'h000321;
        cs_n = 1'b1;
        sck_in = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R10 ext pullup off", {31'd0, sck_pullup}, 32'd0);
        wait_eoc(cyc);
        repeat (3 * DIV + 10) @(negedge clk);
        check("R9 no advance without host clock", {31'd0, sdo}, 32'd0);
        check("R10 ext sck_oe", {31'd0, sck_oe}, 32'd0);
        read_ext(fr);
        check("R9 ext frame", {8'd0, fr}, 32'h00400321);
        check("R12 busy after ext frame", {31'd0, sdo}, 32'd1);

        // R10: return to internal mode at next chip-select fall
        cs_n = 1'b1;
        sck_in = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R10 internal again", {31'd0, sck_pullup}, 32'd1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule